// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block is a sequential integer arithmetic engine that forms either the full product or the quotient and remainder of two 32-bit operands. It computes one partial product or one partial remainder per clock. One 64-bit shifting accumulator and one 33-bit adder/subtractor serve both operations. A caller presents an operation code and two operands together with a one-cycle `start` pulse. It then waits for `done`. The result lands in a pair of result registers, `hi` and `lo`, which can be read at any time.

Signed operations run on operand magnitudes. The signs are applied in a final cycle. Multiply adds the multiplicand into the upper half whenever the low bit of the accumulator is set, then shifts right. Divide shifts left and subtracts trially. When the subtraction goes negative, the old partial remainder is kept, which has the same effect as adding the divisor back. The unit raises no error for a zero divisor or for an out-of-range signed quotient. It always finishes with a defined result, and software decides what that result means.

Top module: `muldiv_iter`

## Requirements
- R1: `op` selects the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide. An unsigned multiply leaves the 64-bit product with bits 63:32 in `hi` and bits 31:0 in `lo`.
- R2: A signed multiply leaves the 64-bit two's-complement product in `hi`:`lo`, including when both operands are 32'h8000_0000.
- R3: An unsigned divide leaves the quotient in `lo` and the remainder in `hi`.
- R4: A signed divide truncates toward zero. The quotient is negative when the operand signs differ, and the remainder carries the sign of the dividend.
- R5: With a zero divisor, either divide gives `lo` = 32'hFFFF_FFFF and `hi` = the dividend, in the normal cycle count.
- R6: `start` sampled high while idle raises `busy` at the next edge. `busy` stays high for exactly 34 cycles: one setup cycle, 32 iterations and one finishing cycle. `done` is high for the single cycle after `busy` falls, and `hi`/`lo` change on the same edge that raises `done`.
- R7: A `start` pulse while `busy` is high is ignored. It does not alter the running result, does not lengthen the operation and does not queue a second one.
- R8: `hi` and `lo` change only on an edge that raises `done`. They hold the previous result while an operation runs and after it ends.
- R9: While `rst_n` is low, `busy`, `done`, `hi` and `lo` are zero, and an operation in progress is abandoned.
- R10: A signed divide of 32'h8000_0000 by 32'hFFFF_FFFF gives quotient 32'h8000_0000 and remainder 0, with no error indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin an operation when idle |
| op | input | 2 | Operation code, see R1 |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `hi`/`lo` are updated |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
The assertions assume that `start` is the only input that can launch work. They also assume the caller never needs a result before `done`. Beyond that, nothing is assumed about `start`: it may be held or pulsed at any time, including while busy. The stimulus drives `start`, `op` and the operands only on falling edges, and it deliberately pulses `start` mid-operation with different operands. It also asserts reset in the middle of a run. Together these exercise the latency and write-back properties under both legal and ignored requests.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ITER   = 2'd2,
    ST_FINISH = 2'd3
  } md_state_e;

  // op[1] = divide, op[0] = unsigned
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

endpackage

// File: rtl/muldiv_rst_sync.sv
module muldiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cap_en,
  output logic load_en,
  output logic step_en,
  output logic fin_en,
  output logic busy,
  output logic done
);
  import muldiv_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  md_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        cnt_d   = '0;
        state_d = ST_ITER;
      end
      ST_ITER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FINISH;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_q == ST_FINISH);
    end
  end

  assign cap_en  = (state_q == ST_IDLE) && start;
  assign load_en = (state_q == ST_SETUP);
  assign step_en = (state_q == ST_ITER);
  assign fin_en  = (state_q == ST_FINISH);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic               is_div,
  input  logic [WIDTH-1:0]   init_lo,
  input  logic [WIDTH-1:0]   init_opnd,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int AW = 2 * WIDTH;

  logic [AW-1:0]    acc_q, acc_d;
  logic [WIDTH-1:0] opnd_q;
  logic [WIDTH:0]   add_a, add_b, add_y;
  logic             trial_neg;

  // shared adder/subtractor
  always_comb begin
    if (is_div) begin
      add_a = acc_q[AW-1:WIDTH-1];
      add_b = {1'b0, opnd_q};
    end else begin
      add_a = {1'b0, acc_q[AW-1:WIDTH]};
      add_b = acc_q[0] ? {1'b0, opnd_q} : '0;
    end
    add_y = add_a + (add_b ^ {(WIDTH+1){is_div}}) + {{WIDTH{1'b0}}, is_div};
  end

  assign trial_neg = add_y[WIDTH];

  always_comb begin
    if (load_en)
      acc_d = {{WIDTH{1'b0}}, init_lo};
    else if (!is_div)
      acc_d = {add_y, acc_q[WIDTH-1:1]};
    else if (trial_neg)
      acc_d = {acc_q[AW-2:0], 1'b0};
    else
      acc_d = {add_y[WIDTH-1:0], acc_q[WIDTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (load_en || step_en) acc_q <= acc_d;
      if (load_en)            opnd_q <= init_opnd;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int AW = 2 * WIDTH;

  logic             rst_i_n;
  logic             cap_en, load_en, step_en, fin_en;
  logic [1:0]       op_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             is_div, is_signed, sign_a, sign_b, div_zero;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [AW-1:0]    prod_fix;
  logic [WIDTH-1:0] quo_fix, rem_fix;

  muldiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .cap_en  (cap_en),
    .load_en (load_en),
    .step_en (step_en),
    .fin_en  (fin_en),
    .busy    (busy),
    .done    (done)
  );

  // operand capture
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (cap_en) begin
      op_q <= op;
      a_q  <= opa;
      b_q  <= opb;
    end
  end

  // sign preparation
  assign is_div    = op_q[1];
  assign is_signed = ~op_q[0];
  assign sign_a    = is_signed & a_q[WIDTH-1];
  assign sign_b    = is_signed & b_q[WIDTH-1];
  assign mag_a     = sign_a ? (~a_q + 1'b1) : a_q;
  assign mag_b     = sign_b ? (~b_q + 1'b1) : b_q;
  assign div_zero  = (b_q == '0);

  muldiv_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .is_div    (is_div),
    .init_lo   (is_div ? mag_a : mag_b),
    .init_opnd (is_div ? mag_b : mag_a),
    .acc_o     (acc)
  );

  // sign fix-up and write-back
  always_comb begin
    prod_fix = (sign_a ^ sign_b) ? (~acc + 1'b1) : acc;
    quo_fix  = ((sign_a ^ sign_b) && !div_zero) ? (~acc[WIDTH-1:0] + 1'b1)
                                                : acc[WIDTH-1:0];
    rem_fix  = sign_a ? (~acc[AW-1:WIDTH] + 1'b1) : acc[AW-1:WIDTH];
    if (is_div) begin
      hi_d = rem_fix;
      lo_d = quo_fix;
    end else begin
      hi_d = prod_fix[AW-1:WIDTH];
      lo_d = prod_fix[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);
  localparam int LAT = WIDTH + 2;
  localparam int BW  = $clog2(LAT + 2);

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == BW'(LAT)));

  // R6
  busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < BW'(LAT)));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_iter muldiv_iter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hi    (hi),
  .lo    (lo)
);

// File: tb/muldiv_iter_bench.sv
module muldiv_iter_bench;
  localparam int PERIOD = 10;
  localparam int NV     = 14;
  localparam int LATE   = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int n_chk  = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  muldiv_iter u_muldiv_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  // {req, op, a, b, hi, lo}
  localparam logic [133:0] VEC [NV] = '{
    {4'd1,  2'b01, 32'h0000_0007, 32'h0000_0005, 32'h0000_0000, 32'h0000_0023}, // R1
    {4'd1,  2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001}, // R1
    {4'd1,  2'b01, 32'h1234_5678, 32'h0000_0010, 32'h0000_0001, 32'h2345_6780}, // R1
    {4'd2,  2'b00, 32'hFFFF_FFFD, 32'h0000_0005, 32'hFFFF_FFFF, 32'hFFFF_FFF1}, // R2
    {4'd2,  2'b00, 32'hFFFF_FFFE, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0008}, // R2
    {4'd2,  2'b00, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000}, // R2
    {4'd3,  2'b11, 32'h0000_0064, 32'h0000_0007, 32'h0000_0002, 32'h0000_000E}, // R3
    {4'd3,  2'b11, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 32'h7FFF_FFFF}, // R3
    {4'd4,  2'b10, 32'hFFFF_FFF9, 32'h0000_0002, 32'hFFFF_FFFF, 32'hFFFF_FFFD}, // R4
    {4'd4,  2'b10, 32'h0000_0007, 32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFD}, // R4
    {4'd4,  2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0003}, // R4
    {4'd10, 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000}, // R10
    {4'd5,  2'b11, 32'h0000_0005, 32'h0000_0000, 32'h0000_0005, 32'hFFFF_FFFF}, // R5
    {4'd5,  2'b10, 32'hFFFF_FFF9, 32'h0000_0000, 32'hFFFF_FFF9, 32'hFFFF_FFFF}  // R5
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; opa = x; opb = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(inout int lat);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] keep;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset outputs", {30'd0, busy, done, hi}, 64'd0);
    check("R9 reset lo", {32'd0, lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][129:128], VEC[i][127:96], VEC[i][95:64]);
      lat = 1;
      wait_done(lat);
      check($sformatf("R%0d vector %0d result", VEC[i][133:130], i), {hi, lo}, VEC[i][63:0]);
    end

    // R6 latency and handshake shape
    launch(2'b01, 32'd3, 32'd3);
    lat = 1;
    check("R6 busy after start", {63'd0, busy}, 64'd1);
    wait_done(lat);
    check("R6 latency", 64'(lat), 64'(LATE));
    check("R6 busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check("R6 done one cycle", {63'd0, done}, 64'd0);

    // R7 start while busy ignored
    launch(2'b01, 32'd7, 32'd5);
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    op = 2'b11; opa = 32'd100; opb = 32'd7; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    // R8 previous result held mid-run
    check("R8 hold during run", {hi, lo}, {32'd0, 32'd9});
    wait_done(lat);
    check("R7 latency unchanged", 64'(lat), 64'(LATE));
    check("R7 result unaffected", {hi, lo}, {32'd0, 32'd35});
    repeat (3) @(negedge clk);
    check("R7 nothing queued", {63'd0, busy}, 64'd0);
    keep = {hi, lo};
    repeat (5) @(negedge clk);
    check("R8 hold after done", {hi, lo}, keep);

    // R9 reset mid-operation
    launch(2'b11, 32'd50, 32'd3);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 abort busy", {62'd0, busy, done}, 64'd0);
    check("R9 abort hilo", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    launch(2'b11, 32'd50, 32'd3);
    lat = 1;
    wait_done(lat);
    check("R3 after reset", {hi, lo}, {32'd2, 32'd16});

    summary();
    $finish;
  end
endmodule